// File: doc/BRIEF.md
# Pin Function Multiplexer with Pad Control

This block configures and multiplexes a small bank of general-purpose pins. Every pin owns a 16-bit configuration word. The word chooses what drives the pin: the GPIO data register or one of three alternate peripheral functions. It also holds the buffer enables, the weak pull, open drain, slew control and hysteresis settings. From that word the block derives the pad control signals. It routes the chosen source's output value and output enable to the pad. It hands the pad level back to the peripherals and to a GPIO data-input register.

Each (pin, function) pair has a direction kind, fixed at build time by a parameter. The kinds are bidirectional, input-only, output-only, self-directing and reserved. The kind decides which buffer enable bits count. Software reaches the configuration words, a GPIO data-output register and the GPIO data-input register over a plain 32-bit register bus. A write lands in one cycle. A read returns its data, registered, in the cycle after the request. No data stream crosses the block, so every pin is plain control or status: there is no valid/ready handshake and no back-pressure.

Top module: `pin_mux_bank`

## Requirements
- R1: The function-select field cfg[1:0] routes the pad output source: 0 selects bit p of the GPIO data-output register, and 1, 2, 3 select per_out[3p+0], per_out[3p+1], per_out[3p+2].
- R2: Configuration fields are: function select [1:0], input enable [2], output enable [3], pull enable [4], pull up (1) / down (0) [5], open drain [6], slow slew [7], hysteresis [8]. Bits [15:9] are stored without effect. After reset every word reads 0 and all pad outputs are 0.
- R3: pad_pull_en is the pull-enable bit while the pad is not driving and 0 while it drives. pad_pull_up is the pull-up bit gated by pad_pull_en.
- R4: pad_odrain and pad_slew follow their bits only while the pad drives. pad_hyst follows its bit only while it does not drive.
- R5: For a bidirectional function (GPIO is always one), pad_oe equals the output-enable bit and pad_ie equals the input-enable bit.
- R6: An input-only function gives pad_ie=1 and pad_oe=0 whatever the enable bits hold. An output-only function gives pad_oe=1, and its pad_ie follows the input-enable bit.
- R7: For a self-directing function, the selected per_oe bit drives pad_oe, pad_ie is its inverse, and both enable bits are ignored.
- R8: A reserved function code is stored and reads back, but it holds pad_oe and pad_ie at 0.
- R9: The GPIO data-input register (byte address 0x44) bit p reads pad_in[p] while pad_ie[p] is 1 and reads 0 otherwise. This holds when a GPIO pin drives.
- R10: Configuration word p sits at byte address 4p and the GPIO data-output register at 0x40. A write takes effect at the clock edge. A read returns its data in bus_rdata in the next cycle, and bus_rdata is 0 in every other cycle. Upper 16 bits read as 0 and are ignored on write. Misaligned or unmapped writes change nothing, and such reads return 0.
- R11: per_in[3p+k] carries pad_in[p] when function k+1 is selected on pin p and pad_ie[p] is 1, and is 0 otherwise.
- R12: pad_out[p] is 0 whenever pad_oe[p] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_rd |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Value driven to each pad |
| pad_oe | output | NUM_PINS | Pad output buffer enable |
| pad_ie | output | NUM_PINS | Pad input buffer enable |
| pad_pull_en | output | NUM_PINS | Weak pull enable |
| pad_pull_up | output | NUM_PINS | Weak pull direction, 1 = up |
| pad_odrain | output | NUM_PINS | Open-drain drive |
| pad_slew | output | NUM_PINS | Slow slew select |
| pad_hyst | output | NUM_PINS | Input hysteresis enable |
| per_out | input | 3*NUM_PINS | Peripheral output values, index 3p+k for function k+1 |
| per_oe | input | 3*NUM_PINS | Peripheral direction for self-directing functions |
| per_in | output | 3*NUM_PINS | Pad levels returned to peripherals |

## Verification
The configuration words are the only state that shapes the pads. A corrupted word therefore shows up at the pad pins in the first cycle after it is written, and at bus_rdata in the cycle after a read of it. A wrong function kind for a pin shows at once as a wrong pad_oe or pad_ie while that function is selected, and a wrong input gate shows on per_in or the data-input register. The bench runs every one of the 512 values of the nine active bits on every pin. For each value it checks all pad signals under every combination of peripheral data, peripheral direction and pad level, so a fault is found within one configuration step.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  typedef enum logic [2:0] {
    FK_BIDIR = 3'd0,
    FK_IN    = 3'd1,
    FK_OUT   = 3'd2,
    FK_SELF  = 3'd3,
    FK_RSVD  = 3'd4
  } fkind_e;

  localparam int CFG_W      = 16;
  localparam int KIND_W     = 3;
  localparam int NUM_FN     = 4;
  localparam int PIN_KIND_W = KIND_W * NUM_FN;

  localparam int F_IBE   = 2;
  localparam int F_OBE   = 3;
  localparam int F_PE    = 4;
  localparam int F_PUP   = 5;
  localparam int F_OD    = 6;
  localparam int F_SLEW  = 7;
  localparam int F_HYST  = 8;

  // Per pin, 12 bits: kind of fsel 3 | fsel 2 | fsel 1 | fsel 0
  localparam logic [4*PIN_KIND_W-1:0] PMX_DEFAULT_KINDS = 48'h810_4C8_300_650;

endpackage

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DO_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] DI_ADDR = 8'h44
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  input  logic [NUM_PINS-1:0]       gpdi,
  output logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  output logic [NUM_PINS-1:0]       gpio_do,
  output logic [31:0]               rdata
);

  logic [CFG_W-1:0] cfg_q [NUM_PINS];
  logic [31:0]      rd_val;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:16];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(p * 4);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[p] <= '0;
      else if (wr && addr == MY_ADDR) cfg_q[p] <= wdata[CFG_W-1:0];
    end

    assign cfg_flat[p*CFG_W +: CFG_W] = cfg_q[p];

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == MY_ADDR) |=> cfg_q[p] == $past(wdata[CFG_W-1:0])); // R10
    AST_CFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == MY_ADDR) |=> rdata == {16'b0, $past(cfg_q[p])}); // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpio_do <= '0;
    else if (wr && addr == DO_ADDR) gpio_do <= wdata[NUM_PINS-1:0];
  end

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (addr == ADDR_W'(p * 4)) rd_val = {16'b0, cfg_q[p]};
    if (addr == DO_ADDR) rd_val = 32'(gpio_do);
    if (addr == DI_ADDR) rd_val = 32'(gpdi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_val : '0;
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == 32'b0); // R10
  AST_MISALIGNED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[1:0] != 2'b00) |=> $stable(cfg_flat) && $stable(gpio_do)); // R10

endmodule

// File: rtl/pmx_pin_ctrl.sv
module pmx_pin_ctrl
  import pmx_pkg::*;
#(
  parameter logic [PIN_KIND_W-1:0] KINDS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  logic             gpio_do,
  input  logic [2:0]       per_out,
  input  logic [2:0]       per_oe,
  input  logic             pad_in,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             pad_ie,
  output logic             pad_pull_en,
  output logic             pad_pull_up,
  output logic             pad_odrain,
  output logic             pad_slew,
  output logic             pad_hyst,
  output logic [2:0]       per_in,
  output logic             di_bit
);

  logic [1:0]        fsel;
  logic [KIND_W-1:0] kind;
  logic              sel_data;
  logic              sel_dir;
  logic              unused_cfg_hi;

  assign fsel          = cfg[1:0];
  assign kind          = KINDS[KIND_W*int'(fsel) +: KIND_W];
  assign unused_cfg_hi = ^cfg[CFG_W-1:9];

  always_comb begin
    case (fsel)
      2'd1:    begin sel_data = per_out[0]; sel_dir = per_oe[0]; end
      2'd2:    begin sel_data = per_out[1]; sel_dir = per_oe[1]; end
      2'd3:    begin sel_data = per_out[2]; sel_dir = per_oe[2]; end
      default: begin sel_data = gpio_do;    sel_dir = 1'b0;      end
    endcase
  end

  always_comb begin
    case (kind)
      FK_BIDIR: begin pad_oe = cfg[F_OBE]; pad_ie = cfg[F_IBE]; end
      FK_IN:    begin pad_oe = 1'b0;       pad_ie = 1'b1;       end
      FK_OUT:   begin pad_oe = 1'b1;       pad_ie = cfg[F_IBE]; end
      FK_SELF:  begin pad_oe = sel_dir;    pad_ie = !sel_dir;   end
      default:  begin pad_oe = 1'b0;       pad_ie = 1'b0;       end
    endcase
  end

  assign pad_out     = pad_oe & sel_data;
  assign pad_pull_en = cfg[F_PE] & ~pad_oe;
  assign pad_pull_up = cfg[F_PUP] & pad_pull_en;
  assign pad_odrain  = cfg[F_OD] & pad_oe;
  assign pad_slew    = cfg[F_SLEW] & pad_oe;
  assign pad_hyst    = cfg[F_HYST] & ~pad_oe;
  assign di_bit      = pad_ie & pad_in;

  for (genvar k = 0; k < 3; k++) begin : g_pin
    assign per_in[k] = (fsel == 2'(k + 1)) & pad_ie & pad_in;
  end

  AST_FIXED_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_IN) |-> (pad_ie && !pad_oe)); // R6
  AST_FIXED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_OUT) |-> pad_oe); // R6
  AST_SELF_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_SELF && fsel != 2'd0) |-> (pad_oe == per_oe[fsel - 2'd1] && pad_ie != pad_oe)); // R7
  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == FK_RSVD) |-> (!pad_oe && !pad_ie)); // R8

endmodule

// File: rtl/pin_mux_bank.sv
module pin_mux_bank
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] DO_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] DI_ADDR = 8'h44,
  parameter logic [NUM_PINS*PIN_KIND_W-1:0] FUNC_KIND = PMX_DEFAULT_KINDS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NUM_PINS-1:0]     pad_in,
  output logic [NUM_PINS-1:0]     pad_out,
  output logic [NUM_PINS-1:0]     pad_oe,
  output logic [NUM_PINS-1:0]     pad_ie,
  output logic [NUM_PINS-1:0]     pad_pull_en,
  output logic [NUM_PINS-1:0]     pad_pull_up,
  output logic [NUM_PINS-1:0]     pad_odrain,
  output logic [NUM_PINS-1:0]     pad_slew,
  output logic [NUM_PINS-1:0]     pad_hyst,
  input  logic [3*NUM_PINS-1:0]   per_out,
  input  logic [3*NUM_PINS-1:0]   per_oe,
  output logic [3*NUM_PINS-1:0]   per_in
);

  localparam int CFG_BITS = NUM_PINS * CFG_W;

  logic [CFG_BITS-1:0] cfg_flat;
  logic [NUM_PINS-1:0] gpio_do;
  logic [NUM_PINS-1:0] gpdi;

  pmx_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DO_ADDR  (DO_ADDR),
    .DI_ADDR  (DI_ADDR)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .gpdi     (gpdi),
    .cfg_flat (cfg_flat),
    .gpio_do  (gpio_do),
    .rdata    (bus_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pmx_pin_ctrl #(
      .KINDS (FUNC_KIND[p*PIN_KIND_W +: PIN_KIND_W])
    ) i_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cfg_flat[p*CFG_W +: CFG_W]),
      .gpio_do     (gpio_do[p]),
      .per_out     (per_out[3*p +: 3]),
      .per_oe      (per_oe[3*p +: 3]),
      .pad_in      (pad_in[p]),
      .pad_out     (pad_out[p]),
      .pad_oe      (pad_oe[p]),
      .pad_ie      (pad_ie[p]),
      .pad_pull_en (pad_pull_en[p]),
      .pad_pull_up (pad_pull_up[p]),
      .pad_odrain  (pad_odrain[p]),
      .pad_slew    (pad_slew[p]),
      .pad_hyst    (pad_hyst[p]),
      .per_in      (per_in[3*p +: 3]),
      .di_bit      (gpdi[p])
    );

    AST_PULL_OFF_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[p] |-> !pad_pull_en[p] && !pad_pull_up[p]); // R3
    AST_HYST_OFF_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[p] |-> !pad_hyst[p]); // R4
    AST_DRIVE_BITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[p] |-> !pad_odrain[p] && !pad_slew[p]); // R4
    AST_NO_OUT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[p] |-> !pad_out[p]); // R12
    AST_DI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_ie[p] |-> !gpdi[p] && per_in[3*p +: 3] == 3'b000); // R9
  end

endmodule

// File: tb/test_pin_mux_bank.sv
module test_pin_mux_bank;
  import pmx_pkg::*;

  localparam int  NP     = 4;
  localparam int  PERIOD = 10;
  localparam logic [47:0] KINDS = 48'h810_4C8_300_650;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   pad_out, pad_oe, pad_ie, pad_pull_en, pad_pull_up;
  logic [NP-1:0]   pad_odrain, pad_slew, pad_hyst;
  logic [3*NP-1:0] per_out = '0, per_oe = '0, per_in;

  int tests = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  pin_mux_bank i_pin_mux_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
    .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up),
    .pad_odrain(pad_odrain), .pad_slew(pad_slew), .pad_hyst(pad_hyst),
    .per_out(per_out), .per_oe(per_oe), .per_in(per_in)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    check("R2", "reset pad_oe", 32'(pad_oe), 0);
    check("R2", "reset pad_ie", 32'(pad_ie), 0);
    check("R2", "reset pulls", 32'({pad_pull_en, pad_hyst}), 0);
    bus_read(8'h00, rv);
    check("R2", "reset cfg0", rv, 0);

    // R10: upper half ignored, misaligned and unmapped accesses
    bus_write(8'h00, 32'hABCD_F123);
    bus_read(8'h00, rv);
    check("R10", "upper bits dropped", rv, 32'h0000_F123);
    bus_write(8'h01, 32'h0000_0000);
    bus_read(8'h00, rv);
    check("R10", "misaligned write ignored", rv, 32'h0000_F123);
    bus_read(8'h01, rv);
    check("R10", "misaligned read", rv, 0);
    bus_read(8'h20, rv);
    check("R10", "unmapped read", rv, 0);
    @(negedge clk);
    check("R10", "rdata idle", bus_rdata, 0);
    bus_write(8'h00, 32'h0);

    for (int p = 0; p < NP; p++) begin
      for (int c = 0; c < 512; c++) begin
        logic [1:0] fs;
        logic [2:0] kd;
        bus_write(8'(p * 4), 32'(c));
        bus_read(8'(p * 4), rv);
        check((c[1:0] != 0 && KINDS[p*12 + c[1:0]*3 +: 3] == 3'd4) ? "R8" : "R2",
              "cfg readback", rv, 32'(c));
        fs = c[1:0];
        kd = KINDS[p*12 + fs*3 +: 3];
        for (int s = 0; s < 8; s++) begin
          logic d, e, pi, sd, se, eoe, eie;
          logic [2:0] epin;
          string tg;
          pi = s[0]; d = s[1]; e = s[2];
          bus_write(8'h40, 32'(d) << p);
          per_out = '0; per_oe = '0; pad_in = '0;
          for (int k = 0; k < 3; k++) begin
            per_out[3*p + k] = d ^ (k == 1);
            per_oe[3*p + k]  = e ^ (k == 2);
          end
          pad_in[p] = pi;
          sd = (fs == 0) ? d : (d ^ (fs == 2));
          se = (fs == 0) ? 1'b0 : (e ^ (fs == 3));
          case (kd)
            3'd0: begin eoe = c[3]; eie = c[2]; tg = "R5"; end
            3'd1: begin eoe = 1'b0; eie = 1'b1; tg = "R6"; end
            3'd2: begin eoe = 1'b1; eie = c[2]; tg = "R6"; end
            3'd3: begin eoe = se;   eie = !se;  tg = "R7"; end
            default: begin eoe = 1'b0; eie = 1'b0; tg = "R8"; end
          endcase
          #1;
          check(tg, "pad_oe", 32'(pad_oe[p]), 32'(eoe));
          check(tg, "pad_ie", 32'(pad_ie[p]), 32'(eie));
          check(eoe ? "R1" : "R12", "pad_out", 32'(pad_out[p]), 32'(eoe & sd));
          check("R3", "pull_en", 32'(pad_pull_en[p]), 32'(c[4] & !eoe));
          check("R3", "pull_up", 32'(pad_pull_up[p]), 32'(c[5] & c[4] & !eoe));
          check("R4", "odrain/slew/hyst",
                32'({pad_odrain[p], pad_slew[p], pad_hyst[p]}),
                32'({c[6] & eoe, c[7] & eoe, c[8] & !eoe}));
          epin = '0;
          if (fs != 0) epin[fs - 2'd1] = eie & pi;
          check("R11", "per_in", 32'(per_in[3*p +: 3]), 32'(epin));
          if (s == 7 || s == 1) begin
            bus_read(8'h44, rv);
            check("R9", "gpio data in", rv, 32'(eie & pi) << p);
          end
        end
      end
      bus_write(8'(p * 4), 32'h0);
    end

    per_out = '0; per_oe = '0;
    bus_write(8'h40, 32'hF);
    bus_read(8'h40, rv);
    check("R10", "gpio data out readback", rv, 32'hF);
    summary();
  end

endmodule